// File: doc/BRIEF.md
# Three-Bit Frame CRC Generator and Checker for a Safety SPI Link

This block computes and checks the 3-bit cyclic redundancy code carried in every 32-bit word of a safety-oriented SPI protocol. A single word presented on `frame_in` is processed two ways at once. The block returns the code that belongs in the word's CRC field, for a transmitter to insert. It also returns a pass flag that says whether the code already in that field is correct, for a receiver to act on.

The protocol has three word kinds. Each kind protects a different bit range, keeps its CRC field in a different place and starts the division from a different seed. All kinds share the generator x^3 + x + 1. A 2-bit selector picks the kind, and the fourth selector value is reserved. Bits go through the division most significant first, and the three field bits are appended after the protected range. For generation, the field bits are taken as zero. A word is correct when the remainder of the whole division is zero.

Both results are registered. They appear one clock cycle after the word and selector are sampled.

Top module: `sspi_crc3_unit`

## Requirements
- R1: With `kind_sel` = 0 (out-of-frame word), `crc_out` is the remainder of dividing bits 31..3, followed by three zero bits, by x^3 + x + 1, starting from seed 101b.
- R2: With `kind_sel` = 1 (in-frame command), `crc_out` covers bits 31..5 with seed 111b, and the field is bits 4..2. Bits 1..0 have no effect on either output.
- R3: With `kind_sel` = 2 (in-frame response), `crc_out` covers bits 26..3 with seed 111b, and the field is bits 2..0. Bits 31..27 have no effect on either output.
- R4: For kinds 0 to 2, `crc_ok` is 1 exactly when dividing the protected range followed by the field bits leaves remainder 000b.
- R5: With `kind_sel` = 3 (reserved), `crc_ok` is 0 and `crc_out` is 000b, whatever the word.
- R6: Both outputs reflect the word and selector sampled at the previous rising edge of `clk`.
- R7: While `rst_n` is low, and at the first edge after it rises, `crc_out` is 000b and `crc_ok` is 0.
- R8: These words pass:
  - Kind 0: 0x00000003, 0xFFFFFFF8, 0x0F0F0F0A and 0x0FF2C8FE.
  - Kind 1: 0x00000004, 0xFFFFFFF7, 0x0F0F0F13 and 0x0FF2C8E7.
  - Kind 2: 0x00000006, 0xFFFFFFFC, 0x0F0F0F0A and 0x0FF2C8FE.
- R9: The words 0x00000000, 0xFFFFFFFF, 0x0F0F0F0F and 0x0FF2C8FA fail under every selector value.
- R10: Writing `crc_out` into the field of its kind, with the rest of the word unchanged, yields a word for which `crc_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_in | input | 32 | Word to generate for or to check |
| kind_sel | input | 2 | Word kind: 0 out-of-frame, 1 in-frame command, 2 in-frame response, 3 reserved |
| crc_out | output | 3 | Code to place in the field of the selected kind |
| crc_ok | output | 1 | 1 when the field of the word holds the correct code |

## Verification
Generation and checking run on the same word in the same cycle. A correct design therefore shows `crc_ok` high exactly when `crc_out` equals the word's own field. The bench provokes both cases on random words:
- In half of the cases it patches the field with the model's code, so the check must pass while generation returns that same field.
- In the other half the field is left random, so generation must still be right while the check usually fails.

Both outputs are judged in the same sample against a bench model. Round-trip runs then feed the block's own `crc_out` back in and expect a pass.

// File: rtl/sspi_crc3_pkg.sv
// Shared constants, word-kind encoding and per-kind layout for the
// three-bit frame CRC unit. Assumes 32-bit words, MSB processed first.
package sspi_crc3_pkg;

    localparam int FRAME_W   = 32;
    localparam int CRC_W     = 3;
    localparam int NUM_KINDS = 3;
    // Feedback taps of x^3 + x + 1 (the x^3 term is implicit).
    localparam logic [CRC_W-1:0] POLY_TAPS = 3'b011;

    typedef enum logic [1:0] {
        KIND_OUT_FRAME = 2'd0,
        KIND_IN_CMD    = 2'd1,
        KIND_IN_RSP    = 2'd2,
        KIND_RESERVED  = 2'd3
    } frame_kind_e;

    // Upper bit of the protected range for a kind.
    function automatic int prot_hi(input int k);
        return (k == 2) ? 26 : 31;
    endfunction

    // Lower bit of the protected range for a kind.
    function automatic int prot_lo(input int k);
        return (k == 1) ? 5 : 3;
    endfunction

    // Lowest bit of the CRC field for a kind.
    function automatic int field_lo(input int k);
        return (k == 1) ? 2 : 0;
    endfunction

    // Start value of the division register for a kind.
    function automatic logic [CRC_W-1:0] seed_of(input int k);
        return (k == 0) ? 3'b101 : 3'b111;
    endfunction

endpackage

// File: rtl/sspi_crc3_chain.sv
// Unrolled MSB-first polynomial division over N input bits.
// Assumes the caller appends any augmentation bits to the input vector.
module sspi_crc3_chain
    import sspi_crc3_pkg::*;
#(
    parameter int               N    = 32,
    parameter logic [CRC_W-1:0] SEED = 3'b111
) (
    input  logic [N-1:0]     bits_in,
    output logic [CRC_W-1:0] rem_out
);

    logic [CRC_W-1:0] stage [0:N];

    assign stage[0] = SEED;

    // One division step per input bit: shift in the bit and fold the carry.
    for (genvar i = 0; i < N; i++) begin : g_step
        assign stage[i+1] = {stage[i][CRC_W-2:0], bits_in[N-1-i]}
                          ^ (stage[i][CRC_W-1] ? POLY_TAPS : '0);
    end

    assign rem_out = stage[N];

endmodule

// File: rtl/sspi_crc3_lane.sv
// One word kind: computes the code for the protected range and compares it
// with the received field. Assumes the field lies below the protected range.
module sspi_crc3_lane
    import sspi_crc3_pkg::*;
#(
    parameter int               HI   = 31,
    parameter int               LO   = 3,
    parameter int               FLD  = 0,
    parameter logic [CRC_W-1:0] SEED = 3'b101
) (
    input  logic [FRAME_W-1:0] frame_in,
    output logic [CRC_W-1:0]   gen_crc,
    output logic               chk_ok
);

    localparam int PW = HI - LO + 1;
    localparam int NW = PW + CRC_W;

    logic [NW-1:0]    aug_bits;
    logic [CRC_W-1:0] field_bits;

    // Protected range augmented by zero bits in the field positions.
    assign aug_bits   = {frame_in[HI:LO], {CRC_W{1'b0}}};
    assign field_bits = frame_in[FLD+CRC_W-1:FLD];

    sspi_crc3_chain #(.N(NW), .SEED(SEED)) u_chain (
        .bits_in (aug_bits),
        .rem_out (gen_crc)
    );

    // Remainder with the field appended equals gen_crc XOR field.
    assign chk_ok = (gen_crc == field_bits);

endmodule

// File: rtl/sspi_crc3_unit.sv
// Three-bit CRC generator and checker for the three safety SPI word kinds.
// All kinds are computed in parallel; the selector picks one and the
// result is registered. Assumes the reserved selector value forces a fail.
module sspi_crc3_unit
    import sspi_crc3_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [1:0]         kind_sel,
    output logic [CRC_W-1:0]   crc_out,
    output logic               crc_ok
);

    logic [CRC_W-1:0] lane_crc [0:NUM_KINDS-1];
    logic             lane_ok  [0:NUM_KINDS-1];
    logic [CRC_W-1:0] sel_crc;
    logic             sel_ok;

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_lane
        sspi_crc3_lane #(
            .HI   (prot_hi(k)),
            .LO   (prot_lo(k)),
            .FLD  (field_lo(k)),
            .SEED (seed_of(k))
        ) u_lane (
            .frame_in (frame_in),
            .gen_crc  (lane_crc[k]),
            .chk_ok   (lane_ok[k])
        );
    end

    // Pick the lane named by the selector; reserved gives zero and fail.
    always_comb begin
        sel_crc = '0;
        sel_ok  = 1'b0;
        case (frame_kind_e'(kind_sel))
            KIND_OUT_FRAME: begin sel_crc = lane_crc[0]; sel_ok = lane_ok[0]; end
            KIND_IN_CMD:    begin sel_crc = lane_crc[1]; sel_ok = lane_ok[1]; end
            KIND_IN_RSP:    begin sel_crc = lane_crc[2]; sel_ok = lane_ok[2]; end
            default:        begin sel_crc = '0;          sel_ok = 1'b0;       end
        endcase
    end

    // Register the selected results with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_out <= '0;
            crc_ok  <= 1'b0;
        end else begin
            crc_out <= sel_crc;
            crc_ok  <= sel_ok;
        end
    end

endmodule

// File: rtl/sspi_crc3_chk.sv
// Property checker for sspi_crc3_unit, attached by bind below.
module sspi_crc3_chk
    import sspi_crc3_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [FRAME_W-1:0] frame_in,
    input logic [1:0]         kind_sel,
    input logic [CRC_W-1:0]   crc_out,
    input logic               crc_ok
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (crc_out == '0 && !crc_ok)); // R7

    AST_RESERVED_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_sel == 2'd3) |=> (crc_out == '0 && !crc_ok)); // R5

    AST_ZERO_WORD_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_in == '0) |=> !crc_ok); // R9

    AST_OOF_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_sel == 2'd0 && frame_in == '0) |=> (crc_out == 3'b011)); // R1

    AST_CMD_LOW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && kind_sel == 2'd1 && $past(kind_sel) == 2'd1
         && frame_in[31:2] == $past(frame_in[31:2]))
        |=> ($stable(crc_out) && $stable(crc_ok))); // R2

    AST_RSP_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && kind_sel == 2'd2 && $past(kind_sel) == 2'd2
         && frame_in[26:0] == $past(frame_in[26:0]))
        |=> ($stable(crc_out) && $stable(crc_ok))); // R3

endmodule

bind sspi_crc3_unit sspi_crc3_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_in (frame_in),
    .kind_sel (kind_sel),
    .crc_out  (crc_out),
    .crc_ok   (crc_ok)
);

// File: tb/tb_sspi_crc3_unit.sv
module tb_sspi_crc3_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] frame_in;
    logic [1:0]  kind_sel;
    logic [2:0]  crc_out;
    logic        crc_ok;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    sspi_crc3_unit dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_in (frame_in),
        .kind_sel (kind_sel),
        .crc_out  (crc_out),
        .crc_ok   (crc_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Division by x^3 + x + 1, MSB first, over f[hi:lo] then the tail bits.
    function automatic logic [2:0] model_rem(input logic [31:0] f, input int hi,
                                             input int lo, input logic [2:0] seed,
                                             input logic [2:0] tail);
        logic [2:0] r = seed;
        for (int i = hi; i >= lo; i--)
            r = {r[1:0], f[i]} ^ (r[2] ? 3'b011 : 3'b000);
        for (int j = 2; j >= 0; j--)
            r = {r[1:0], tail[j]} ^ (r[2] ? 3'b011 : 3'b000);
        return r;
    endfunction

    // Expected generated code per requirements R1, R2, R3, R5.
    function automatic logic [2:0] exp_crc(input logic [31:0] f, input logic [1:0] k);
        case (k)
            2'd0:    return model_rem(f, 31, 3, 3'b101, 3'b000);
            2'd1:    return model_rem(f, 31, 5, 3'b111, 3'b000);
            2'd2:    return model_rem(f, 26, 3, 3'b111, 3'b000);
            default: return 3'b000;
        endcase
    endfunction

    // Expected check flag per requirements R4, R5.
    function automatic logic exp_ok(input logic [31:0] f, input logic [1:0] k);
        case (k)
            2'd0:    return model_rem(f, 31, 3, 3'b101, f[2:0]) == 3'b000;
            2'd1:    return model_rem(f, 31, 5, 3'b111, f[4:2]) == 3'b000;
            2'd2:    return model_rem(f, 26, 3, 3'b111, f[2:0]) == 3'b000;
            default: return 1'b0;
        endcase
    endfunction

    // Place a code into the field of a kind.
    function automatic logic [31:0] with_field(input logic [31:0] f, input logic [1:0] k,
                                               input logic [2:0] c);
        logic [31:0] g = f;
        if (k == 2'd1) g[4:2] = c;
        else           g[2:0] = c;
        return g;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive away from the edge, let one edge register it, sample after it.
    task automatic apply(input logic [31:0] f, input logic [1:0] k);
        @(negedge clk);
        frame_in = f;
        kind_sel = k;
        @(posedge clk);
        #1;
    endtask

    task automatic run(input string req, input logic [31:0] f, input logic [1:0] k);
        apply(f, k);
        check({req, " crc_out"}, {29'd0, crc_out}, {29'd0, exp_crc(f, k)});
        check({req, " crc_ok"},  {31'd0, crc_ok},  {31'd0, exp_ok(f, k)});
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] ok_vec [12];
        logic [1:0]  ok_kind [12];
        logic [31:0] bad_vec [4];
        logic [2:0]  c1, c2;
        logic        o1;
        void'($urandom(32'd20240613));
        ok_vec  = '{32'h00000003, 32'hFFFFFFF8, 32'h0F0F0F0A, 32'h0FF2C8FE,
                    32'h00000004, 32'hFFFFFFF7, 32'h0F0F0F13, 32'h0FF2C8E7,
                    32'h00000006, 32'hFFFFFFFC, 32'h0F0F0F0A, 32'h0FF2C8FE};
        ok_kind = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 2'd1,
                    2'd2, 2'd2, 2'd2, 2'd2};
        bad_vec = '{32'h00000000, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'h0FF2C8FA};

        // R7: reset clears outputs even with a passing word applied.
        rst_n    = 1'b0;
        frame_in = 32'h00000003;
        kind_sel = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset crc_out", {29'd0, crc_out}, 32'd0);
        check("R7 reset crc_ok",  {31'd0, crc_ok},  32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: listed passing words, and the field equals the generated code.
        for (int i = 0; i < 12; i++) begin
            apply(ok_vec[i], ok_kind[i]);
            check("R8 pass flag", {31'd0, crc_ok}, 32'd1);
            check("R8 code", {29'd0, crc_out},
                  {29'd0, (ok_kind[i] == 2'd1) ? ok_vec[i][4:2] : ok_vec[i][2:0]});
        end

        // R9, R5: listed failing words under every selector value.
        for (int i = 0; i < 4; i++)
            for (int k = 0; k < 4; k++) begin
                apply(bad_vec[i], 2'(k));
                check("R9 fail flag", {31'd0, crc_ok}, 32'd0);
                if (k == 3) check("R5 reserved code", {29'd0, crc_out}, 32'd0);
            end

        // R1 directed: zero out-of-frame word yields code 011b.
        run("R1", 32'h00000000, 2'd0);

        // R6: output follows the word of the previous edge on back-to-back words.
        @(negedge clk); frame_in = 32'h00000004; kind_sel = 2'd1;
        @(negedge clk);
        check("R6 first word", {31'd0, crc_ok}, 32'd1);
        frame_in = 32'h00000000;
        @(negedge clk);
        check("R6 second word", {31'd0, crc_ok}, 32'd0);

        // R2, R3: ignored bits leave both outputs unchanged.
        for (int n = 0; n < 20; n++) begin
            logic [31:0] f = $urandom();
            apply(f, 2'd1); c1 = crc_out; o1 = crc_ok;
            apply(f ^ {30'd0, 2'($urandom())}, 2'd1);
            check("R2 low bits ignored", {28'd0, crc_ok, crc_out}, {28'd0, o1, c1});
            f = with_field(f, 2'd2, exp_crc(f, 2'd2));
            apply(f, 2'd2); c2 = crc_out; o1 = crc_ok;
            check("R3 patched word passes", {31'd0, o1}, 32'd1);
            apply(f ^ {5'($urandom()), 27'd0}, 2'd2);
            check("R3 high bits ignored", {28'd0, crc_ok, crc_out}, {28'd0, o1, c2});
        end

        // R10: feed the block's own code back into the field.
        for (int n = 0; n < 30; n++) begin
            logic [31:0] f = $urandom();
            logic [1:0]  k = 2'($urandom_range(2, 0));
            apply(f, k);
            c1 = crc_out;
            apply(with_field(f, k, c1), k);
            check("R10 round trip", {31'd0, crc_ok}, 32'd1);
        end

        // R1 R2 R3 R4 R5: random words, half patched with the model code.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] f = $urandom();
            logic [1:0]  k = 2'($urandom());
            if ($urandom_range(1, 0) == 1 && k != 2'd3) f = with_field(f, k, exp_crc(f, k));
            run("R1 R2 R3 R4 R5 random", f, k);
        end

        // R7: reset mid-run clears registered results.
        apply(32'h0FF2C8FE, 2'd0);
        check("R7 pre-reset pass", {31'd0, crc_ok}, 32'd1);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R7 mid-run reset", {28'd0, crc_ok, crc_out}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule